// File: doc/BRIEF.md
# USB Line State and Speed Detector

This block watches the two data lines of a low-speed/full-speed USB port using a fast local clock. Each line passes through a two-flop synchronizer. Every clock cycle, the block turns the synchronized pair into a line-state code: J, K, single-ended zero (SE0) or single-ended one (SE1). It times each SE0 period. When the SE0 ends, it reports a bus reset or a low-speed keep-alive as a one-cycle pulse.

In automatic configuration, the block learns the device speed from the level the bus rests at. If D+ rests high, the device is full-speed. If D- rests high, the device is low-speed. The block also offers a low-speed mode with full-speed polarity, for hub segments after a preamble. It outputs the current speed mode and the polarity that bit-recovery logic downstream must use for J.

The line-state output is a stream with a valid strobe and no ready. Once valid rises, it stays high and a new code appears every cycle. Downstream logic has no way to stall this stream and must take each code in the cycle it appears. The parameter `CLK_HZ` gives the sampling clock frequency. From it, the block works out the SE0 cycle limits: more than 1.2 µs is a keep-alive and more than 2.5 µs is a bus reset. At the default 48 MHz, these limits are 57 and 120 cycles.

Top module: `usb_line_speed_det`

## Requirements
- R1: The line code and valid strobe reflect the D+/D- levels 3 clock cycles after they change. Valid stays low during reset and for the first 2 cycles after reset. From the third cycle onward, valid is high.
- R2: In every speed mode, both lines low gives code 2 (SE0) and both lines high gives code 3 (SE1).
- R3: Speed mode codes are 0 = unresolved, 1 = full-speed, 2 = low-speed and 3 = low-speed with full-speed polarity.
  - In modes 1 and 3, D+ high with D- low is code 0 (J) and the reverse is code 1 (K).
  - In mode 2, D- high is J and D+ high is K.
  - `j_dp_high_o` is 0 only in mode 2.
- R4: Configuration `cfg_speed_i` encodes 0 = automatic, 1 = fixed full-speed, 2 = fixed low-speed, and 3 = automatic.
  - While the mode is unresolved, both differential patterns give code 0 (J).
  - Under automatic configuration, the first differential sample sets the mode: 1 if D+ is high, 2 if D- is high.
- R5: When an SE0 that lasted more than the reset limit (121 or more cycles at 48 MHz) ends, `bus_rst_o` pulses for one cycle. The speed mode then returns to the configured setting.
- R6: When an SE0 ends, `keep_alive_o` pulses for one cycle only if all of the following hold:
  - the mode is 2;
  - the SE0 lasted more than the keep-alive limit (58 or more cycles);
  - the SE0 did not exceed the reset limit (120 or fewer cycles).
- R7: When an SE0 ends on a differential level under automatic configuration, the mode becomes 1 or 2 according to which line is high. Under fixed configuration, a short SE0 leaves the mode unchanged.
- R8: A one-cycle pulse on `pre_i` sets the mode to 3 in the next cycle, unless an SE0 ends in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_speed_i | input | 2 | Speed configuration (0/3 automatic, 1 full, 2 low) |
| pre_i | input | 1 | Preamble seen; switch to low-speed with full-speed polarity |
| dp_i | input | 1 | Raw D+ level |
| dm_i | input | 1 | Raw D- level |
| line_code_o | output | 2 | Line state: 0 J, 1 K, 2 SE0, 3 SE1 |
| line_vld_o | output | 1 | Line code valid strobe |
| bus_rst_o | output | 1 | One-cycle bus reset pulse at SE0 end |
| keep_alive_o | output | 1 | One-cycle keep-alive pulse at SE0 end |
| speed_o | output | 2 | Current speed mode |
| j_dp_high_o | output | 1 | 1 when J is D+ high, 0 when J is D- high |

## Verification
Each line code, and each reset or keep-alive pulse, is due on the third rising edge after the input change that causes it. The bench therefore drives on the falling edge and checks at the falling edge that follows that third rising edge. A one-cycle pulse is caught there. A background counter also confirms that exactly one pulse fired in the window. Mode changes caused by `pre_i` are due one edge later. A mode change caused by a line sample affects the line code one cycle after the mode itself changes, so the bench waits a few extra cycles before it checks the code.

// File: rtl/usb_lsd_pkg.sv
package usb_lsd_pkg;

  typedef enum logic [1:0] {
    LC_J   = 2'd0,
    LC_K   = 2'd1,
    LC_SE0 = 2'd2,
    LC_SE1 = 2'd3
  } line_code_e;

  typedef enum logic [1:0] {
    SPD_NONE   = 2'd0,
    SPD_FULL   = 2'd1,
    SPD_LOW    = 2'd2,
    SPD_LOW_FP = 2'd3
  } spd_mode_e;

  // Whole cycles in a span of tenths of a microsecond, rounded down.
  function automatic int unsigned tenth_us_cycles(input int unsigned hz,
                                                  input int unsigned tenths);
    longint unsigned prod;
    prod = longint'(hz) * longint'(tenths);
    return int'(prod / 64'd10_000_000);
  endfunction

endpackage

// File: rtl/usb_lsd_sync.sv
module usb_lsd_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         q_vld
);
  logic [W-1:0]      stg_q [STAGES];
  logic [STAGES-1:0] fill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q[0]  <= '0;
      fill_q[0] <= 1'b0;
    end else begin
      stg_q[0]  <= d;
      fill_q[0] <= 1'b1;
    end
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q[s]  <= '0;
        fill_q[s] <= 1'b0;
      end else begin
        stg_q[s]  <= stg_q[s-1];
        fill_q[s] <= fill_q[s-1];
      end
    end
  end

  assign q     = stg_q[STAGES-1];
  assign q_vld = fill_q[STAGES-1];
endmodule

// File: rtl/usb_lsd_classify.sv
module usb_lsd_classify
  import usb_lsd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sdp,
  input  logic       sdm,
  input  logic       s_vld,
  input  spd_mode_e  mode,
  output line_code_e code,
  output logic       code_vld
);
  line_code_e code_d;

  always_comb begin
    unique case ({sdp, sdm})
      2'b00:   code_d = LC_SE0;
      2'b11:   code_d = LC_SE1;
      default: begin
        unique case (mode)
          SPD_NONE: code_d = LC_J;
          SPD_LOW:  code_d = sdm ? LC_J : LC_K;
          default:  code_d = sdp ? LC_J : LC_K;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code     <= LC_J;
      code_vld <= 1'b0;
    end else begin
      code     <= code_d;
      code_vld <= s_vld;
    end
  end
endmodule

// File: rtl/usb_lsd_se0_timer.sv
module usb_lsd_se0_timer #(
  parameter int unsigned KA_CYC  = 57,
  parameter int unsigned RST_CYC = 120,
  localparam int unsigned CW     = $clog2(RST_CYC + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic se0,
  input  logic is_low,
  output logic se0_end,
  output logic se0_long,
  output logic rst_pulse,
  output logic ka_pulse
);
  localparam logic [CW-1:0] SAT_V = CW'(RST_CYC + 1);
  localparam logic [CW-1:0] RST_V = CW'(RST_CYC);
  localparam logic [CW-1:0] KA_V  = CW'(KA_CYC);

  logic [CW-1:0] cnt_q;
  logic          se0_mid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (se0)     cnt_q <= (cnt_q == SAT_V) ? cnt_q : cnt_q + 1'b1;
    else              cnt_q <= '0;
  end

  assign se0_end  = !se0 && (cnt_q != '0);
  assign se0_long = cnt_q > RST_V;
  assign se0_mid  = cnt_q > KA_V;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pulse <= 1'b0;
      ka_pulse  <= 1'b0;
    end else begin
      rst_pulse <= se0_end && se0_long;
      ka_pulse  <= se0_end && !se0_long && se0_mid && is_low;
    end
  end
endmodule

// File: rtl/usb_lsd_mode.sv
module usb_lsd_mode
  import usb_lsd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg,
  input  logic       sdp,
  input  logic       sdm,
  input  logic       s_vld,
  input  logic       se0_end,
  input  logic       se0_long,
  input  logic       pre,
  output spd_mode_e  mode_eff,
  output logic       j_dp_high
);
  spd_mode_e cfg_mode, mode_q, idle_mode, base_mode;
  logic      cfg_auto, diff;

  always_comb begin
    unique case (cfg)
      2'd1:    cfg_mode = SPD_FULL;
      2'd2:    cfg_mode = SPD_LOW;
      default: cfg_mode = SPD_NONE;
    endcase
  end

  assign cfg_auto  = (cfg_mode == SPD_NONE);
  assign diff      = s_vld && (sdp ^ sdm);
  assign idle_mode = sdp ? SPD_FULL : SPD_LOW;
  assign base_mode = se0_long ? SPD_NONE : mode_q;
  assign mode_eff  = (mode_q != SPD_NONE) ? mode_q : cfg_mode;
  assign j_dp_high = (mode_eff != SPD_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SPD_NONE;
    end else if (se0_end) begin
      mode_q <= (cfg_auto && diff) ? idle_mode : base_mode;
    end else if (pre) begin
      mode_q <= SPD_LOW_FP;
    end else if (mode_eff == SPD_NONE && diff) begin
      mode_q <= idle_mode;
    end
  end
endmodule

// File: rtl/usb_line_speed_det.sv
module usb_line_speed_det
  import usb_lsd_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 48_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_speed_i,
  input  logic       pre_i,
  input  logic       dp_i,
  input  logic       dm_i,
  output logic [1:0] line_code_o,
  output logic       line_vld_o,
  output logic       bus_rst_o,
  output logic       keep_alive_o,
  output logic [1:0] speed_o,
  output logic       j_dp_high_o
);
  localparam int unsigned KA_CYC  = tenth_us_cycles(CLK_HZ, 12);
  localparam int unsigned RST_CYC = tenth_us_cycles(CLK_HZ, 25);

  logic [1:0] s_lines;
  logic       s_vld, sdp, sdm;
  logic       se0_s, se0_end, se0_long;
  spd_mode_e  mode_eff;
  line_code_e code;

  usb_lsd_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({dp_i, dm_i}),
    .q     (s_lines),
    .q_vld (s_vld)
  );

  assign sdp   = s_lines[1];
  assign sdm   = s_lines[0];
  assign se0_s = s_vld && !sdp && !sdm;

  usb_lsd_classify u_cls (
    .clk      (clk),
    .rst_n    (rst_n),
    .sdp      (sdp),
    .sdm      (sdm),
    .s_vld    (s_vld),
    .mode     (mode_eff),
    .code     (code),
    .code_vld (line_vld_o)
  );

  usb_lsd_se0_timer #(.KA_CYC(KA_CYC), .RST_CYC(RST_CYC)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .se0       (se0_s),
    .is_low    (mode_eff == SPD_LOW),
    .se0_end   (se0_end),
    .se0_long  (se0_long),
    .rst_pulse (bus_rst_o),
    .ka_pulse  (keep_alive_o)
  );

  usb_lsd_mode u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg       (cfg_speed_i),
    .sdp       (sdp),
    .sdm       (sdm),
    .s_vld     (s_vld),
    .se0_end   (se0_end),
    .se0_long  (se0_long),
    .pre       (pre_i),
    .mode_eff  (mode_eff),
    .j_dp_high (j_dp_high_o)
  );

  assign line_code_o = code;
  assign speed_o     = mode_eff;
endmodule

// File: rtl/usb_lsd_chk.sv
module usb_lsd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_speed_i,
  input logic       pre_i,
  input logic       dp_i,
  input logic       dm_i,
  input logic [1:0] line_code_o,
  input logic       line_vld_o,
  input logic       bus_rst_o,
  input logic       keep_alive_o,
  input logic [1:0] speed_o,
  input logic       se0_end
);
  AST_VLD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    line_vld_o |=> line_vld_o); // R1

  AST_SE0_FROM_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (line_vld_o && line_code_o == 2'd2) |-> ($past(dp_i, 3) == 1'b0 && $past(dm_i, 3) == 1'b0)); // R2

  AST_SE1_FROM_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (line_vld_o && line_code_o == 2'd3) |-> ($past(dp_i, 3) && $past(dm_i, 3))); // R2

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_o |=> !bus_rst_o); // R5

  AST_RST_RESTORES_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rst_o && (cfg_speed_i == 2'd1 || cfg_speed_i == 2'd2)) |-> speed_o == cfg_speed_i); // R5

  AST_KA_ONLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    keep_alive_o |-> ($past(speed_o) == 2'd2 && !bus_rst_o)); // R6

  AST_PRE_SETS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_i && !se0_end) |=> speed_o == 2'd3); // R8
endmodule

bind usb_line_speed_det usb_lsd_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_speed_i  (cfg_speed_i),
  .pre_i        (pre_i),
  .dp_i         (dp_i),
  .dm_i         (dm_i),
  .line_code_o  (line_code_o),
  .line_vld_o   (line_vld_o),
  .bus_rst_o    (bus_rst_o),
  .keep_alive_o (keep_alive_o),
  .speed_o      (speed_o),
  .se0_end      (se0_end)
);

// File: tb/tb_usb_line_speed_det.sv
`timescale 1ns/1ps
module tb_usb_line_speed_det;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_speed_i = 2'd0;
  logic       pre_i = 1'b0;
  logic       dp_i = 1'b0;
  logic       dm_i = 1'b0;
  logic [1:0] line_code_o;
  logic       line_vld_o, bus_rst_o, keep_alive_o, j_dp_high_o;
  logic [1:0] speed_o;

  int checks = 0;
  int fails  = 0;
  int n_rst  = 0;
  int n_ka   = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  usb_line_speed_det dut (
    .clk(clk), .rst_n(rst_n), .cfg_speed_i(cfg_speed_i), .pre_i(pre_i),
    .dp_i(dp_i), .dm_i(dm_i), .line_code_o(line_code_o), .line_vld_o(line_vld_o),
    .bus_rst_o(bus_rst_o), .keep_alive_o(keep_alive_o), .speed_o(speed_o),
    .j_dp_high_o(j_dp_high_o)
  );

  always @(posedge clk) begin
    if (bus_rst_o)    n_rst++;
    if (keep_alive_o) n_ka++;
  end

  // cfg[17:16] len[15:8] dp[7] dm[6] rst[5] ka[4] mode[3:2] code[1:0]
  localparam int NV = 11;
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 8'd10,  1'b0, 1'b1, 1'b0, 1'b0, 2'd2, 2'd0},
    {2'd0, 8'd60,  1'b0, 1'b1, 1'b0, 1'b1, 2'd2, 2'd0},
    {2'd0, 8'd57,  1'b0, 1'b1, 1'b0, 1'b0, 2'd2, 2'd0},
    {2'd0, 8'd58,  1'b0, 1'b1, 1'b0, 1'b1, 2'd2, 2'd0},
    {2'd0, 8'd120, 1'b0, 1'b1, 1'b0, 1'b1, 2'd2, 2'd0},
    {2'd0, 8'd121, 1'b1, 1'b0, 1'b1, 1'b0, 2'd1, 2'd0},
    {2'd0, 8'd60,  1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 2'd0},
    {2'd1, 8'd130, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 2'd1},
    {2'd1, 8'd10,  1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 2'd1},
    {2'd2, 8'd125, 1'b1, 1'b0, 1'b1, 1'b0, 2'd2, 2'd1},
    {2'd2, 8'd70,  1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 2'd1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic lines(input logic p, input logic m);
    dp_i = p;
    dm_i = m;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
    end
  end

  initial begin
    int r0, k0;
    lines(1'b0, 1'b0);
    tick(3);
    // Reset state
    chk("R1 vld in reset", int'(line_vld_o), 0);
    chk("R5 no reset pulse in reset", int'(bus_rst_o), 0);
    chk("R3 unresolved mode in reset", int'(speed_o), 0);
    chk("R3 polarity in reset", int'(j_dp_high_o), 1);
    rst_n = 1'b1;
    tick(2);
    chk("R1 vld after 2 cycles", int'(line_vld_o), 0);
    tick(1);
    chk("R1 vld after 3 cycles", int'(line_vld_o), 1);
    chk("R2 SE0 code", int'(line_code_o), 2);
    tick(2);
    lines(1'b1, 1'b1);
    tick(3);
    chk("R2 SE1 code", int'(line_code_o), 3);
    chk("R4 unresolved after SE1", int'(speed_o), 0);
    lines(1'b0, 1'b1);
    tick(3);
    chk("R4 unresolved pattern is J", int'(line_code_o), 0);
    chk("R4 resolves low-speed", int'(speed_o), 2);
    chk("R3 low polarity", int'(j_dp_high_o), 0);
    lines(1'b1, 1'b0);
    tick(3);
    chk("R3 D+ high is K in low-speed", int'(line_code_o), 1);
    chk("R4 resolved mode holds", int'(speed_o), 2);
    lines(1'b0, 1'b1);
    tick(4);

    // Table of SE0 durations and idle levels
    for (int i = 0; i < NV; i++) begin
      logic [17:0] v;
      v = VEC[i];
      cfg_speed_i = v[17:16];
      r0 = n_rst;
      k0 = n_ka;
      lines(1'b0, 1'b0);
      tick(int'(v[15:8]));
      lines(v[7], v[6]);
      tick(3);
      chk($sformatf("R5 vec%0d reset pulse", i), int'(bus_rst_o), int'(v[5]));
      chk($sformatf("R6 vec%0d keep-alive pulse", i), int'(keep_alive_o), int'(v[4]));
      chk($sformatf("R7 vec%0d speed mode", i), int'(speed_o), int'(v[3:2]));
      tick(3);
      chk($sformatf("R3 vec%0d idle code", i), int'(line_code_o), int'(v[1:0]));
      chk($sformatf("R5 vec%0d reset count", i), n_rst - r0, int'(v[5]));
      chk($sformatf("R6 vec%0d keep-alive count", i), n_ka - k0, int'(v[4]));
    end

    // Preamble mode
    cfg_speed_i = 2'd0;
    tick(4);
    chk("R4 auto resolves full-speed", int'(speed_o), 1);
    pre_i = 1'b1;
    tick(1);
    pre_i = 1'b0;
    chk("R8 preamble mode", int'(speed_o), 3);
    chk("R3 preamble polarity", int'(j_dp_high_o), 1);
    lines(1'b0, 1'b1);
    tick(3);
    chk("R3 D- high is K after preamble", int'(line_code_o), 1);
    r0 = n_rst;
    k0 = n_ka;
    lines(1'b0, 1'b0);
    tick(70);
    lines(1'b1, 1'b0);
    tick(3);
    chk("R6 no keep-alive in preamble mode", int'(keep_alive_o), 0);
    chk("R7 idle sets full-speed", int'(speed_o), 1);
    tick(3);
    chk("R6 keep-alive count preamble", n_ka - k0, 0);
    chk("R5 reset count preamble", n_rst - r0, 0);

    done = 1'b1;
    summary();
  end
endmodule